// File: doc/BRIEF.md
# POST Code Capture FIFO

This block sits beside the host I/O decoder and records every byte the host writes to the power-on self-test code port at I/O address 0x0080. Each accepted byte is stored in a 16-entry first-in first-out buffer. Alongside the byte, the buffer stores the value of a free-running 24-bit timestamp, so firmware can later tell when each code arrived and how far apart the codes were.

Local firmware sees a capture-read port and a small status set. Firmware drains the buffer by pulsing the read strobe while the not-empty flag is set. Each pulse pops the oldest entry. An interrupt is raised while the number of buffered entries is above a programmable level. A sticky overrun flag records any write that was lost because the buffer was full. The host bus is modelled as a single-cycle write strobe with a 16-bit address and 16-bit data. When a link delivers a 16-bit write to the port as one transfer, only its low byte is kept.

Top module: `post_cap_top`

## Requirements
- R1: A cycle with `host_wr_i` high and `host_addr_i` equal to 0x0080 is a capture request. A write to any other address (for example 0x0081, 0x0090, 0x0180) leaves every output unchanged.
- R2: `cap_data_o` presents the oldest entry. Bits [7:0] hold `host_data_i[7:0]` of the captured write, and `host_data_i[15:8]` is discarded. Bits [31:8] hold the timestamp value in effect in the cycle of the write.
- R3: A cycle with `fw_rd_i` high while the buffer is non-empty removes the oldest entry, and entries leave in arrival order. A read while empty returns 0 on `cap_data_o` and changes no state.
- R4: `stat_count_o` equals the number of buffered entries. `stat_not_empty_o` is high exactly when that number is nonzero.
- R5: The buffer holds 16 entries. A capture request while it is full is dropped, unless a read pops an entry in the same cycle; in that case the write is stored.
- R6: `stat_overrun_o` is set by a dropped write and stays set until a cycle with `fw_ovr_clr_i` high clears it. If a drop and a clear occur in the same cycle, the flag stays set.
- R7: `irq_o` is high exactly while `stat_count_o` is greater than `fw_level_i`. It falls as soon as the count drops to or below the level.
- R8: The timestamp starts at 0 after reset and advances by one every PRESCALE clocks (default 4). It wraps from all ones to zero with no other effect.
- R9: After reset the count is 0, not-empty, overrun and interrupt are low, and `cap_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr_i | input | 16 | Host I/O write address |
| host_data_i | input | 16 | Host write data; only bits [7:0] are captured |
| fw_rd_i | input | 1 | Firmware capture-read strobe; pops one entry |
| fw_ovr_clr_i | input | 1 | Firmware write-one-to-clear of the overrun flag |
| fw_level_i | input | 5 | Interrupt level; interrupt while count exceeds it |
| cap_data_o | output | 32 | Oldest entry: timestamp [31:8], data [7:0]; 0 when empty |
| stat_count_o | output | 5 | Number of buffered entries |
| stat_not_empty_o | output | 1 | Buffer holds at least one entry |
| stat_overrun_o | output | 1 | Sticky flag: a write was dropped |
| irq_o | output | 1 | Fill level above `fw_level_i` |

## Verification
The bench targets the following corner cases:
- A write to a full buffer. A design that got this wrong would overwrite the oldest code or corrupt the count past 16.
- A write and a read in the same cycle at full. A wrong design would drop a code that had room.
- A drop in the same cycle as an overrun clear. A wrong design would lose the only record of the lost byte.
- The interrupt at count equal to the level, at level 0 and at level 16. An off-by-one would fire one entry early or never.
- A wide write with a non-zero high byte, stray addresses next to 0x0080, and reads of an empty buffer. Wrong handling would show up as corrupted data, phantom entries, or a count that moves.

// File: rtl/post_cap_pkg.sv
package post_cap_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned TS_W    = 24;
  localparam int unsigned ENTRY_W = DATA_W + TS_W;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [DATA_W-1:0] data;
  } cap_entry_t;
endpackage

// File: rtl/post_cap_tstamp.sv
module post_cap_tstamp #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned TS_W     = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic tick;

  generate
    if (PRESCALE <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ts_o <= '0;
    else if (tick) ts_o <= ts_o + 1'b1;  // wraps silently
  end

  assert_ts_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(ts_o));
  assert_ts_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> ts_o == TS_W'($past(ts_o) + 1'b1));
endmodule

// File: rtl/post_cap_fifo.sv
module post_cap_fifo #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  output logic [ENTRY_W-1:0] rdata_o,
  output logic [CNT_W-1:0]   count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  assert_no_push_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && count_o == CNT_W'(DEPTH)) |-> pop_i);
  assert_no_pop_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_o != '0);
  assert_pop_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> count_o == CNT_W'($past(count_o) - 1'b1));
endmodule

// File: rtl/post_cap_status.sv
module post_cap_status #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             overrun_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     overrun_o <= 1'b0;
    else if (drop_i) overrun_o <= 1'b1;  // set wins over clear
    else if (clr_i)  overrun_o <= 1'b0;
  end

  assign irq_o = (count_i > level_i);

  assert_ovr_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> overrun_o);
  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_i) |=> overrun_o);
  assert_ovr_no_self_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!overrun_o && !drop_i) |=> !overrun_o);
endmodule

// File: rtl/post_cap_top.sv
module post_cap_top #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned PRESCALE  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HDATA_W   = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0080,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        host_wr_i,
  input  logic [ADDR_W-1:0]           host_addr_i,
  input  logic [HDATA_W-1:0]          host_data_i,
  input  logic                        fw_rd_i,
  input  logic                        fw_ovr_clr_i,
  input  logic [CNT_W-1:0]            fw_level_i,
  output logic [post_cap_pkg::ENTRY_W-1:0] cap_data_o,
  output logic [CNT_W-1:0]            stat_count_o,
  output logic                        stat_not_empty_o,
  output logic                        stat_overrun_o,
  output logic                        irq_o
);
  import post_cap_pkg::*;

  logic [TS_W-1:0]    ts;
  logic               hit, full, pop, push, drop;
  cap_entry_t         wentry;
  logic [ENTRY_W-1:0] head;

  assign hit  = host_wr_i && (host_addr_i == ADDR_W'(PORT_ADDR));
  assign full = (stat_count_o == CNT_W'(DEPTH));
  assign pop  = fw_rd_i && stat_not_empty_o;
  assign push = hit && (!full || pop);
  assign drop = hit && full && !pop;

  assign wentry.ts   = ts;
  assign wentry.data = host_data_i[DATA_W-1:0];

  post_cap_tstamp #(.PRESCALE(PRESCALE), .TS_W(TS_W)) u_tstamp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts)
  );

  post_cap_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(wentry),
    .rdata_o(head),
    .count_o(stat_count_o)
  );

  post_cap_status #(.CNT_W(CNT_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drop_i   (drop),
    .clr_i    (fw_ovr_clr_i),
    .count_i  (stat_count_o),
    .level_i  (fw_level_i),
    .overrun_o(stat_overrun_o),
    .irq_o    (irq_o)
  );

  assign stat_not_empty_o = (stat_count_o != '0);
  assign cap_data_o       = stat_not_empty_o ? head : '0;

  assert_stray_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !fw_rd_i) |=> stat_count_o == $past(stat_count_o));
  assert_empty_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_rd_i && !stat_not_empty_o && !hit) |=> !stat_not_empty_o);
  assert_push_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !fw_rd_i && !full) |=> stat_count_o == CNT_W'($past(stat_count_o) + 1'b1));
endmodule

// File: tb/post_cap_top_tb_top.sv
module post_cap_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int PRESCALE   = 4;
  localparam int MAX_CYC    = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [15:0] host_data = '0;
  logic        fw_rd = 1'b0;
  logic        fw_clr = 1'b0;
  logic [4:0]  fw_level = '0;
  logic [31:0] cap_data;
  logic [4:0]  stat_count;
  logic        stat_ne, stat_ovr, irq;

  int checks = 0;
  int fails  = 0;
  int cyc_n  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  post_cap_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_data_i(host_data),
    .fw_rd_i(fw_rd), .fw_ovr_clr_i(fw_clr), .fw_level_i(fw_level),
    .cap_data_o(cap_data), .stat_count_o(stat_count),
    .stat_not_empty_o(stat_ne), .stat_overrun_o(stat_ovr), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_q[$];
  int          m_pre = 0;
  logic [23:0] m_ts = '0;
  bit          m_ovr = 0;
  bit          m_pop, m_hit, m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_pre = 0; m_ts = '0; m_ovr = 0;
    end else begin
      m_pop = fw_rd && (m_q.size() > 0);
      m_hit = host_wr && (host_addr == 16'h0080);
      m_acc = m_hit && (m_q.size() < DEPTH || m_pop);
      if (m_pop) void'(m_q.pop_front());
      if (m_acc) m_q.push_back({m_ts, host_data[7:0]});
      if (m_hit && !m_acc) m_ovr = 1;
      else if (fw_clr)     m_ovr = 0;
      if (m_pre == PRESCALE - 1) begin m_pre = 0; m_ts = m_ts + 1'b1; end
      else m_pre = m_pre + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R8 cap_data", cap_data, (m_q.size() > 0) ? m_q[0] : 32'h0);
    chk("R4 count", 32'(stat_count), 32'(m_q.size()));
    chk("R4 not_empty", 32'(stat_ne), 32'(m_q.size() > 0));
    chk("R6 overrun", 32'(stat_ovr), 32'(m_ovr));
    chk("R7 irq", 32'(irq), 32'(m_q.size() > int'(fw_level)));
  endtask

  // one cycle: compare, then drive inputs for the next edge
  task automatic cyc(bit wr, logic [15:0] a, logic [15:0] d, bit rd, bit clr);
    @(negedge clk);
    compare_all();
    host_wr = wr; host_addr = a; host_data = d; fw_rd = rd; fw_clr = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 16'h0, 0, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > MAX_CYC) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_n, MAX_CYC);
      finish_run();
    end
  end

  initial begin
    fw_level = 5'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 reset count", 32'(stat_count), 32'h0);
    chk("R9 reset flags", {29'h0, stat_ne, stat_ovr, irq}, 32'h0);
    chk("R9 reset data", cap_data, 32'h0);

    // R2 captures with differing timestamps, wide write keeps low byte
    cyc(1, 16'h0080, 16'h0011, 0, 0);
    idle(5);
    cyc(1, 16'h0080, 16'hA5C3, 0, 0);
    idle(1);
    // R1 stray addresses
    cyc(1, 16'h0081, 16'h0055, 0, 0);
    cyc(1, 16'h0090, 16'h0066, 0, 0);
    cyc(1, 16'h0180, 16'h0077, 0, 0);
    cyc(1, 16'h0000, 16'h0088, 0, 0);
    idle(1);
    @(negedge clk);
    chk("R1 stray writes ignored", 32'(stat_count), 32'd2);
    chk("R2 first entry low byte", 32'(cap_data[7:0]), 32'h11);
    // R3 drain in order, then empty reads
    cyc(0, 16'h0, 16'h0, 1, 0);
    cyc(0, 16'h0, 16'h0, 0, 0);
    @(negedge clk);
    chk("R2 high byte dropped", 32'(cap_data[7:0]), 32'hC3);
    cyc(0, 16'h0, 16'h0, 1, 0);
    cyc(0, 16'h0, 16'h0, 1, 0);
    cyc(0, 16'h0, 16'h0, 1, 0);
    idle(1);
    @(negedge clk);
    chk("R3 empty read returns zero", cap_data, 32'h0);
    chk("R3 empty read keeps count", 32'(stat_count), 32'h0);

    // R5 R7 fill to full with level 16, then 15
    fw_level = 5'd16;
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'h0080, 16'(i + 8'h40), 0, 0);
    idle(1);
    @(negedge clk);
    chk("R7 no irq at count equal level", 32'(irq), 32'h0);
    fw_level = 5'd15;
    idle(1);
    // drop into full buffer
    cyc(1, 16'h0080, 16'h00EE, 0, 0);
    idle(1);
    @(negedge clk);
    chk("R5 full write dropped", 32'(stat_count), 32'd16);
    chk("R6 overrun set", 32'(stat_ovr), 32'h1);
    // push with pop at full is accepted
    cyc(1, 16'h0080, 16'h00DD, 1, 0);
    // drop and clear in same cycle: set wins
    cyc(1, 16'h0080, 16'h00CC, 0, 1);
    idle(1);
    @(negedge clk);
    chk("R6 drop beats clear", 32'(stat_ovr), 32'h1);
    cyc(0, 16'h0, 16'h0, 0, 1);
    idle(1);
    @(negedge clk);
    chk("R6 clear", 32'(stat_ovr), 32'h0);
    // drain; irq falls at level
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 16'h0, 16'h0, 1, 0);
    idle(1);
    // level 0: single entry raises irq
    fw_level = 5'd0;
    cyc(1, 16'h0080, 16'h0099, 0, 0);
    idle(2);
    @(negedge clk);
    chk("R7 irq at level zero", 32'(irq), 32'h1);
    cyc(0, 16'h0, 16'h0, 1, 0);
    idle(2);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 500 == 0) fw_level = 5'(r[20:16] % 17);
      cyc(r[1:0] != 0, r[3] ? 16'h0080 : {8'h0, r[15:8]}, r[31:16],
          r[5:4] == 2'b11, r[9:6] == 0);
    end
    idle(40);
    finish_run();
  end
endmodule